// File: doc/BRIEF.md
# Card Data Transfer DMA Request Controller

This block sits between a card-side data engine, a local word FIFO and a memory-side DMA channel. It paces a single card data transfer. It raises a DMA request when the FIFO can usefully take or give data. It decides when the transfer-complete flag (called DTO here) is set. Software, or the command path, starts a transfer with a direction, a DMA/programmed-I/O choice and a byte count. The controller then moves 32-bit words between the memory-side stream and the card-side stream through its internal FIFO.

In a write, words flow from the memory stream into the FIFO and then out to the card. A byte count of zero makes the write open-ended. Fetching goes on for as long as the FIFO has room, and only the card's end-of-transfer pulse stops it. Any words still buffered at that point are dropped. In a read, words flow from the card into the FIFO and then out to memory. When DMA is used, DTO waits until the FIFO has been emptied to memory. Without DMA, DTO follows the card's end pulse at once, and software drains the leftovers over the same memory-side stream.

All data ports are valid/ready streams. A word moves on a rising clock edge where both valid and ready are high. The controller drops ready when the FIFO is full or the direction does not match. A source may hold valid for as long as it likes, and a sink may hold ready low indefinitely without loss. The command port also uses valid/ready, and ready is high only while no transfer is outstanding.

Top module: `cdma_req_ctrl`

## Requirements
- R1: `cmd_ready` is high exactly when no transfer is outstanding (after reset, or from the cycle after DTO is set). It drops in the cycle after a command is accepted, so a second command is refused until DTO. Accepting a command empties the FIFO.
- R2: During a DMA write that still needs data, `dma_req` is high while FIFO free space is at least `TX_WM` words, and low otherwise.
- R3: A write with a nonzero byte count N accepts exactly ceil(N/4) words on the memory input stream, and `mem_in_ready` stays low afterwards.
- R4: A write with byte count 0 keeps accepting memory words until the FIFO is full, whatever the card has consumed. From the cycle DTO is set, `dma_req` and `mem_in_ready` are low.
- R5: For a write, DTO is set on the edge where `card_done` is sampled high, so it is visible one cycle later. Buffered words are discarded and `card_out_valid` is low from then on.
- R6: During a DMA read, `dma_req` is high when the FIFO holds at least `RX_WM` words, or when the card has ended and at least one word remains. It is low otherwise.
- R7: In a DMA read, DTO stays 0 while any word remains in the FIFO. It is set on the edge after the last word leaves, so it is visible two cycles after the final memory-side handshake.
- R8: In a non-DMA transfer, `dma_req` never rises. A non-DMA read sets DTO one cycle after `card_done`, even with words still buffered, and those words stay readable in order on `mem_out`.
- R9: DTO is reported as bit 3 of `sts_word`, and all other bits read 0. DTO stays set until a cycle with `clr_we` high and `clr_wdata[3]` high. Other bits of `clr_wdata` have no effect, and a new DTO in the same cycle as a clear wins.
- R10: Words leave the FIFO in arrival order. `card_in_ready` during a read is high exactly while the FIFO holds fewer than `DEPTH` words, so nothing is lost or overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_write | input | 1 | 1 = memory to card, 0 = card to memory |
| cmd_dma | input | 1 | 1 = pace with DMA requests, 0 = programmed I/O |
| cmd_bytes | input | BCW | Byte count, 0 = open-ended |
| card_done | input | 1 | Pulse: card-side data phase has finished |
| mem_in_valid | input | 1 | Memory-side write word valid |
| mem_in_ready | output | 1 | Controller takes a memory-side word |
| mem_in_data | input | DW | Memory-side write word |
| card_out_valid | output | 1 | Word available for the card |
| card_out_ready | input | 1 | Card takes the word |
| card_out_data | output | DW | Word toward the card |
| card_in_valid | input | 1 | Word from the card valid |
| card_in_ready | output | 1 | Controller takes the card word |
| card_in_data | input | DW | Word from the card |
| mem_out_valid | output | 1 | Word available for memory |
| mem_out_ready | input | 1 | Memory side takes the word |
| mem_out_data | output | DW | Word toward memory |
| dma_req | output | 1 | DMA service request |
| clr_we | input | 1 | Status clear write strobe |
| clr_wdata | input | 32 | Clear data, 1 in bit 3 clears DTO |
| sts_word | output | 32 | Raw status, DTO in bit 3 |

## Verification
If the sequencer lands in the wrong state, the fault shows up within a cycle. `cmd_ready` would stay low, or DTO would arrive early while `mem_out_valid` is still high. A wrong FIFO level is caught on the cycle the bench's own fill model disagrees with `dma_req`, `card_in_ready` or `mem_out_valid`. Word data that is lost or reordered shows up on the next handshake, against the bench's queue. A fetch limiter that counts wrongly shows up as one word too many or too few accepted on `mem_in` before the card ends.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_DRAIN = 2'd2
  } cdma_state_e;

  localparam int DONE_BIT = 3;
endpackage

// File: rtl/cdma_fifo.sv
module cdma_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DW-1:0]              pop_data,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full     = (level == LW'(DEPTH));
  assign empty    = (level == '0);
  assign do_push  = push && !full && !flush;
  assign do_pop   = pop && !empty && !flush;
  assign pop_data = store[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/cdma_fetch_lim.sv
module cdma_fetch_lim #(
  parameter int BCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [BCW-1:0] byte_cnt,
  input  logic           take,
  output logic           open
);
  localparam int WCW = BCW - 1;

  logic [BCW:0]   padded;
  logic [WCW-1:0] target, taken;
  logic           open_ended;

  assign padded = {1'b0, byte_cnt} + (BCW + 1)'(3);
  assign open   = open_ended || (taken < target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target     <= '0;
      taken      <= '0;
      open_ended <= 1'b0;
    end else if (load) begin
      target     <= padded[BCW:2];
      taken      <= '0;
      open_ended <= (byte_cnt == '0);
    end else if (take && !open_ended) begin
      taken <= taken + 1'b1;
    end
  end
endmodule

// File: rtl/cdma_seq.sv
module cdma_seq
  import cdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_fire,
  input  logic        cmd_wr,
  input  logic        cmd_use_dma,
  input  logic        card_done,
  input  logic        fifo_empty,
  input  logic        clr_hit,
  output cdma_state_e state,
  output logic        dir_wr,
  output logic        use_dma,
  output logic        dto,
  output logic        flush_wr
);
  logic end_xfer, dto_set;

  assign end_xfer = (state == ST_XFER) && card_done;
  assign flush_wr = end_xfer && dir_wr;
  assign dto_set  = (end_xfer && (dir_wr || !use_dma)) ||
                    ((state == ST_DRAIN) && fifo_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      dir_wr  <= 1'b0;
      use_dma <= 1'b0;
      dto     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_fire) begin
          state   <= ST_XFER;
          dir_wr  <= cmd_wr;
          use_dma <= cmd_use_dma;
        end
        ST_XFER: if (card_done)
          state <= (!dir_wr && use_dma) ? ST_DRAIN : ST_IDLE;
        ST_DRAIN: if (fifo_empty) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (dto_set)      dto <= 1'b1;
      else if (clr_hit) dto <= 1'b0;
    end
  end
endmodule

// File: rtl/cdma_req_gen.sv
module cdma_req_gen
  import cdma_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TX_WM = 8,
  parameter int RX_WM = 8
) (
  input  cdma_state_e              state,
  input  logic                     dir_wr,
  input  logic                     use_dma,
  input  logic                     fetch_open,
  input  logic [$clog2(DEPTH):0]   level,
  output logic                     dma_req
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic [LW-1:0] free_words;
  logic          wr_want, rd_want;

  assign free_words = LW'(DEPTH) - level;
  assign wr_want = (state == ST_XFER) && dir_wr && fetch_open &&
                   (free_words >= LW'(TX_WM));
  assign rd_want = !dir_wr && (state != ST_IDLE) &&
                   ((level >= LW'(RX_WM)) || ((state == ST_DRAIN) && (level != '0)));
  assign dma_req = use_dma && (wr_want || rd_want);
endmodule

// File: rtl/cdma_req_ctrl.sv
module cdma_req_ctrl
  import cdma_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int BCW   = 16,
  parameter int TX_WM = 8,
  parameter int RX_WM = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic           cmd_write,
  input  logic           cmd_dma,
  input  logic [BCW-1:0] cmd_bytes,
  input  logic           card_done,
  input  logic           mem_in_valid,
  output logic           mem_in_ready,
  input  logic [DW-1:0]  mem_in_data,
  output logic           card_out_valid,
  input  logic           card_out_ready,
  output logic [DW-1:0]  card_out_data,
  input  logic           card_in_valid,
  output logic           card_in_ready,
  input  logic [DW-1:0]  card_in_data,
  output logic           mem_out_valid,
  input  logic           mem_out_ready,
  output logic [DW-1:0]  mem_out_data,
  output logic           dma_req,
  input  logic           clr_we,
  input  logic [31:0]    clr_wdata,
  output logic [31:0]    sts_word
);
  localparam int LW = $clog2(DEPTH) + 1;

  cdma_state_e   state;
  logic          dir_wr, use_dma, dto, flush_wr;
  logic          cmd_fire, fetch_open, clr_hit;
  logic          fifo_full, fifo_empty, fifo_push, fifo_pop;
  logic [LW-1:0] level;
  logic [DW-1:0] fifo_out;
  logic          in_xfer;

  assign in_xfer   = (state == ST_XFER);
  assign cmd_ready = (state == ST_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign clr_hit   = clr_we && clr_wdata[DONE_BIT];

  assign mem_in_ready   = in_xfer && dir_wr && !fifo_full && fetch_open;
  assign card_out_valid = in_xfer && dir_wr && !fifo_empty;
  assign card_in_ready  = in_xfer && !dir_wr && !fifo_full;
  assign mem_out_valid  = !dir_wr && !fifo_empty;
  assign card_out_data  = fifo_out;
  assign mem_out_data   = fifo_out;

  assign fifo_push = dir_wr ? (mem_in_valid && mem_in_ready)
                            : (card_in_valid && card_in_ready);
  assign fifo_pop  = dir_wr ? (card_out_valid && card_out_ready)
                            : (mem_out_valid && mem_out_ready);

  always_comb begin
    sts_word           = '0;
    sts_word[DONE_BIT] = dto;
  end

  cdma_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_fire    (cmd_fire),
    .cmd_wr      (cmd_write),
    .cmd_use_dma (cmd_dma),
    .card_done   (card_done),
    .fifo_empty  (fifo_empty),
    .clr_hit     (clr_hit),
    .state       (state),
    .dir_wr      (dir_wr),
    .use_dma     (use_dma),
    .dto         (dto),
    .flush_wr    (flush_wr)
  );

  cdma_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (cmd_fire || flush_wr),
    .push      (fifo_push),
    .push_data (dir_wr ? mem_in_data : card_in_data),
    .pop       (fifo_pop),
    .pop_data  (fifo_out),
    .level     (level),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  cdma_fetch_lim #(.BCW(BCW)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd_fire),
    .byte_cnt (cmd_bytes),
    .take     (mem_in_valid && mem_in_ready),
    .open     (fetch_open)
  );

  cdma_req_gen #(.DEPTH(DEPTH), .TX_WM(TX_WM), .RX_WM(RX_WM)) u_req (
    .state      (state),
    .dir_wr     (dir_wr),
    .use_dma    (use_dma),
    .fetch_open (fetch_open),
    .level      (level),
    .dma_req    (dma_req)
  );
endmodule

// File: rtl/cdma_req_ctrl_chk.sv
module cdma_req_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          dma_req,
  input logic          dto,
  input logic          dir_wr,
  input logic          use_dma,
  input logic [LW-1:0] level,
  input logic          mem_in_valid,
  input logic          mem_in_ready,
  input logic          card_in_valid,
  input logic          card_in_ready,
  input logic          mem_out_valid,
  input logic          mem_out_ready,
  input logic          card_out_valid,
  input logic          clr_we,
  input logic          clr_bit3
);
  a_r1_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  a_r4_req_stops_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dto) |-> (!dma_req && !mem_in_ready));

  a_r5_leftover_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dto) && dir_wr) |-> !card_out_valid);

  a_r7_done_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dto) && !dir_wr && use_dma) |-> (level == '0));

  a_r8_no_req_without_dma: assert property (@(posedge clk) disable iff (!rst_n)
    !use_dma |-> !dma_req);

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (dto && !(clr_we && clr_bit3)) |=> dto);

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_in_valid && mem_in_ready) || (card_in_valid && card_in_ready))
      |-> (level < LW'(DEPTH)));

  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_out_valid && mem_out_ready) |-> (level != '0));
endmodule

bind cdma_req_ctrl cdma_req_ctrl_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_valid      (cmd_valid),
  .cmd_ready      (cmd_ready),
  .dma_req        (dma_req),
  .dto            (dto),
  .dir_wr         (dir_wr),
  .use_dma        (use_dma),
  .level          (level),
  .mem_in_valid   (mem_in_valid),
  .mem_in_ready   (mem_in_ready),
  .card_in_valid  (card_in_valid),
  .card_in_ready  (card_in_ready),
  .mem_out_valid  (mem_out_valid),
  .mem_out_ready  (mem_out_ready),
  .card_out_valid (card_out_valid),
  .clr_we         (clr_we),
  .clr_bit3       (clr_wdata[3])
);

// File: tb/sim_cdma_req_ctrl.sv
module sim_cdma_req_ctrl;
  localparam int DEPTH = 16;
  localparam int RXW   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid, cmd_ready, cmd_write, cmd_dma;
  logic [15:0] cmd_bytes;
  logic        card_done;
  logic        mem_in_valid, mem_in_ready;
  logic [31:0] mem_in_data;
  logic        card_out_valid, card_out_ready;
  logic [31:0] card_out_data;
  logic        card_in_valid, card_in_ready;
  logic [31:0] card_in_data;
  logic        mem_out_valid, mem_out_ready;
  logic [31:0] mem_out_data;
  logic        dma_req, clr_we;
  logic [31:0] clr_wdata, sts_word;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cdma_req_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_dma(cmd_dma), .cmd_bytes(cmd_bytes), .card_done(card_done),
    .mem_in_valid(mem_in_valid), .mem_in_ready(mem_in_ready), .mem_in_data(mem_in_data),
    .card_out_valid(card_out_valid), .card_out_ready(card_out_ready), .card_out_data(card_out_data),
    .card_in_valid(card_in_valid), .card_in_ready(card_in_ready), .card_in_data(card_in_data),
    .mem_out_valid(mem_out_valid), .mem_out_ready(mem_out_ready), .mem_out_data(mem_out_data),
    .dma_req(dma_req), .clr_we(clr_we), .clr_wdata(clr_wdata), .sts_word(sts_word)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int words_of(input int nbytes);
    return (nbytes + 3) / 4;
  endfunction

  task automatic clear_dto();
    clr_we = 1'b1; clr_wdata = 32'h8;
    @(negedge clk);
    clr_we = 1'b0; clr_wdata = '0;
  endtask

  task automatic start_cmd(input bit wr, input bit dma, input int nbytes);
    cmd_valid = 1'b1; cmd_write = wr; cmd_dma = dma; cmd_bytes = nbytes[15:0];
    #1;
    chk(cmd_ready == 1'b1, "R1", "ready while idle", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
    chk(cmd_ready == 1'b0, "R1", "ready after accept", cmd_ready, 0);
  endtask

  task automatic run_write(input int nbytes, input bit dma);
    int words, acc, cons, busy_bad, data_bad, req_bad, extra;
    logic [31:0] q[$];
    words = words_of(nbytes);
    acc = 0; cons = 0; busy_bad = 0; data_bad = 0; req_bad = 0; extra = 0;
    clear_dto();
    start_cmd(1'b1, dma, nbytes);
    if (dma) chk(dma_req == 1'b1, "R2", "request on empty fifo", dma_req, 1);
    else     chk(dma_req == 1'b0, "R8", "no request in pio", dma_req, 0);
    for (int c = 0; c < 3000 && cons < words; c++) begin
      mem_in_valid = ($urandom % 4) != 0;
      mem_in_data = $urandom;
      card_out_ready = ($urandom % 3) != 0;
      #1;
      if (cmd_ready) busy_bad++;
      if (!dma && dma_req) req_bad++;
      if (card_out_valid && card_out_ready) begin
        if (q.size() == 0) data_bad++;
        else if (q.pop_front() != card_out_data) data_bad++;
        cons++;
      end
      if (mem_in_valid && mem_in_ready) begin
        q.push_back(mem_in_data);
        acc++;
      end
      @(negedge clk);
    end
    mem_in_valid = 1'b1; card_out_ready = 1'b0;
    for (int c = 0; c < 4; c++) begin
      #1;
      if (mem_in_ready) extra++;
      @(negedge clk);
    end
    mem_in_valid = 1'b0;
    chk(acc == words, "R3", "words fetched", acc, words);
    chk(extra == 0, "R3", "ready after count met", extra, 0);
    chk(busy_bad == 0, "R1", "refused while busy", busy_bad, 0);
    chk(data_bad == 0, "R10", "write data order", data_bad, 0);
    if (!dma) chk(req_bad == 0, "R8", "pio write request", req_bad, 0);
    card_done = 1'b1;
    @(negedge clk);
    card_done = 1'b0;
    #1;
    chk(sts_word == 32'h8, "R5", "done after card end", sts_word, 32'h8);
    chk(cmd_ready == 1'b1, "R1", "idle after done", cmd_ready, 1);
    chk(dma_req == 1'b0, "R4", "request after done", dma_req, 0);
  endtask

  task automatic run_undef();
    int acc, cons, data_bad;
    logic [31:0] q[$];
    acc = 0; cons = 0; data_bad = 0;
    clear_dto();
    start_cmd(1'b1, 1'b1, 0);
    for (int c = 0; c < 1000 && cons < 6; c++) begin
      mem_in_valid = $urandom % 2;
      mem_in_data = $urandom;
      card_out_ready = $urandom % 2;
      #1;
      if (card_out_valid && card_out_ready) begin
        if (q.size() == 0) data_bad++;
        else if (q.pop_front() != card_out_data) data_bad++;
        cons++;
      end
      if (mem_in_valid && mem_in_ready) begin
        q.push_back(mem_in_data);
        acc++;
      end
      @(negedge clk);
    end
    card_out_ready = 1'b0; mem_in_valid = 1'b1;
    for (int c = 0; c < 30; c++) begin
      mem_in_data = $urandom;
      #1;
      if (mem_in_ready) acc++;
      @(negedge clk);
    end
    #1;
    chk(acc - cons == DEPTH, "R4", "open-ended fetch fills fifo", acc - cons, DEPTH);
    chk(dma_req == 1'b0, "R2", "no request when full", dma_req, 0);
    chk(data_bad == 0, "R10", "open write order", data_bad, 0);
    card_done = 1'b1;
    @(negedge clk);
    card_done = 1'b0;
    #1;
    chk(sts_word == 32'h8, "R5", "done on card end", sts_word, 32'h8);
    chk(card_out_valid == 1'b0, "R5", "leftover discarded", card_out_valid, 0);
    chk(dma_req == 1'b0 && mem_in_ready == 1'b0, "R4", "fetch stopped at done",
        {dma_req, mem_in_ready}, 0);
    mem_in_valid = 1'b0;
  endtask

  task automatic run_read_dma(input int m);
    int fill, pushed, req_bad, rdy_bad, v_bad, data_bad, dto_bad;
    bit ended, exp_req, cin, mout;
    logic [31:0] q[$];
    fill = 0; pushed = 0; req_bad = 0; rdy_bad = 0; v_bad = 0; data_bad = 0; dto_bad = 0;
    ended = 0;
    clear_dto();
    start_cmd(1'b0, 1'b1, 0);
    for (int c = 0; c < 3000 && pushed < m; c++) begin
      card_in_valid = $urandom % 2;
      card_in_data = $urandom;
      mem_out_ready = ($urandom % 4) == 0;
      #1;
      exp_req = (fill >= RXW);
      if (dma_req != exp_req) req_bad++;
      if (card_in_ready != (fill < DEPTH)) rdy_bad++;
      if (mem_out_valid != (fill > 0)) v_bad++;
      cin = card_in_valid && card_in_ready;
      mout = mem_out_valid && mem_out_ready;
      if (mout) begin
        if (q.size() == 0) data_bad++;
        else if (q.pop_front() != mem_out_data) data_bad++;
      end
      if (cin) begin q.push_back(card_in_data); pushed++; end
      fill = fill + int'(cin) - int'(mout);
      @(negedge clk);
    end
    card_in_valid = 1'b0; mem_out_ready = 1'b0; card_done = 1'b1;
    @(negedge clk);
    card_done = 1'b0; ended = 1;
    for (int c = 0; c < 3000 && fill > 0; c++) begin
      mem_out_ready = $urandom % 2;
      #1;
      exp_req = (fill >= RXW) || (ended && fill > 0);
      if (dma_req != exp_req) req_bad++;
      if (sts_word[3]) dto_bad++;
      mout = mem_out_valid && mem_out_ready;
      if (mout) begin
        if (q.size() == 0) data_bad++;
        else if (q.pop_front() != mem_out_data) data_bad++;
        fill--;
      end
      @(negedge clk);
    end
    mem_out_ready = 1'b0;
    #1;
    chk(sts_word[3] == 1'b0, "R7", "done not yet after last pop", sts_word[3], 0);
    chk(dto_bad == 0, "R7", "done while words remain", dto_bad, 0);
    @(negedge clk);
    #1;
    chk(sts_word[3] == 1'b1, "R7", "done after flush", sts_word[3], 1);
    chk(req_bad == 0, "R6", "read request rule", req_bad, 0);
    chk(rdy_bad == 0 && v_bad == 0, "R10", "read fill flags", rdy_bad + v_bad, 0);
    chk(data_bad == 0, "R10", "read data order", data_bad, 0);
  endtask

  task automatic run_read_pio();
    int req_bad, data_bad;
    logic [31:0] q[$];
    req_bad = 0; data_bad = 0;
    start_cmd(1'b0, 1'b0, 0);
    mem_out_ready = 1'b0;
    for (int c = 0; c < 5; c++) begin
      card_in_valid = 1'b1;
      card_in_data = $urandom;
      #1;
      if (dma_req) req_bad++;
      if (card_in_ready) q.push_back(card_in_data);
      @(negedge clk);
    end
    card_in_valid = 1'b0;
    card_done = 1'b1; clr_we = 1'b1; clr_wdata = 32'h8;
    @(negedge clk);
    card_done = 1'b0; clr_we = 1'b0; clr_wdata = '0;
    #1;
    chk(sts_word == 32'h8, "R9", "set wins over clear", sts_word, 32'h8);
    chk(mem_out_valid == 1'b1, "R8", "leftover kept after done", mem_out_valid, 1);
    chk(cmd_ready == 1'b1, "R8", "pio read ends at card end", cmd_ready, 1);
    chk(req_bad == 0 && dma_req == 1'b0, "R8", "pio read request", req_bad, 0);
    mem_out_ready = 1'b1;
    for (int c = 0; c < 2; c++) begin
      #1;
      if (!mem_out_valid || q.size() == 0) data_bad++;
      else if (q.pop_front() != mem_out_data) data_bad++;
      @(negedge clk);
    end
    mem_out_ready = 1'b0;
    #1;
    chk(data_bad == 0, "R8", "leftover readable in order", data_bad, 0);
    chk(mem_out_valid == 1'b1, "R8", "words still buffered", mem_out_valid, 1);
    @(negedge clk);
    start_cmd(1'b0, 1'b0, 0);
    chk(mem_out_valid == 1'b0, "R1", "accept empties fifo", mem_out_valid, 0);
    card_done = 1'b1;
    @(negedge clk);
    card_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cmd_valid = 0; cmd_write = 0; cmd_dma = 0; cmd_bytes = '0; card_done = 0;
    mem_in_valid = 0; mem_in_data = '0; card_out_ready = 0;
    card_in_valid = 0; card_in_data = '0; mem_out_ready = 0;
    clr_we = 0; clr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(cmd_ready == 1'b1, "R1", "reset ready", cmd_ready, 1);
    chk(sts_word == 32'h0, "R9", "reset status", sts_word, 0);
    chk({dma_req, card_out_valid, mem_out_valid, card_in_ready, mem_in_ready} == 5'b0,
        "R1", "reset outputs", {dma_req, card_out_valid, mem_out_valid}, 0);
    @(negedge clk);
    run_write(1, 1'b1);
    run_write(4, 1'b1);
    run_write(100, 1'b1);
    for (int i = 0; i < 3; i++) run_write(1 + int'($urandom % 60), i != 1);
    run_undef();
    clr_we = 1'b1; clr_wdata = 32'hFFFF_FFF7;
    @(negedge clk);
    clr_we = 1'b0;
    #1;
    chk(sts_word == 32'h8, "R9", "other clear bits ignored", sts_word, 32'h8);
    @(negedge clk);
    clear_dto();
    #1;
    chk(sts_word == 32'h0, "R9", "clear by bit 3", sts_word, 0);
    @(negedge clk);
    run_read_dma(24);
    @(negedge clk);
    run_read_dma(5);
    @(negedge clk);
    run_read_pio();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule